// File: doc/BRIEF.md
# Programmable Pixel Clock Divider

This block turns a fast reference clock into a pixel-rate clock enable. Rather than producing a derived clock, it raises `pix_en` for exactly one reference cycle in every period of N reference cycles. Logic downstream advances one pixel on each such cycle. The division ratio comes from a single configuration word. In that word, the divisor code is split into a low field and a high field at non-adjacent bit positions. The stored code is the divisor minus two. A separate bypass bit selects divide-by-one, which makes the enable permanently high.

A configuration write does not disturb the period in progress. The written setting is held in a pending stage. It becomes active only at the next terminal count, so the output never shows a shortened or stretched period. The divisor currently in force is reported continuously on `div_eff`.

Top module: `pclk_divider`

## Requirements
- R1: While reset (`rst_n` low) is asserted, `pix_en` is 0 and `div_eff` reports 2 (all code bits zero, bypass clear).
- R2: In the configuration word, the low code field is bits [LO_W-1:0], the bypass bit is bit LO_W, and the high code field is bits [HI_POS+HI_W-1:HI_POS]. The high field forms the upper bits of the code. With bypass clear, the divisor is ({high, low}) + 2, and `div_eff` reports it. All other word bits have no effect.
- R3: With bypass set, `pix_en` is high on every reference cycle and `div_eff` reports 1, whatever the code fields hold.
- R4: With bypass clear and divisor N, `pix_en` is high for exactly one reference cycle and low for N-1 cycles in every period, for odd and even N alike.
- R5: Every divisor from 2 to 2^(LO_W+HI_W)+1 is reachable. With the default widths (5 and 5) this is 2 to 1025, and `div_eff` never leaves the range 1 to that maximum.
- R6: A written setting takes effect only at the next terminal count. The period in progress completes with the old divisor, and `div_eff` changes only in a cycle in which `pix_en` is high.
- R7: Several writes before the same terminal count leave only the last written setting to take effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | REG_W | Configuration word (code fields and bypass bit) |
| pix_en | output | 1 | Pixel clock enable, one reference cycle wide |
| div_eff | output | LO_W+HI_W+1 | Divisor currently in force (1 in bypass) |

## Verification
On every cycle, the assertions check the following:
- single-cycle width of the enable pulse;
- continuous enable in bypass;
- legal range of the reported divisor;
- divisor changes happening only on a pulse;
- each measured period, tracked by a cycle counter in the checker, equal to the divisor that was in force during it.

Only the bench's scenarios can show the correct field placement, the offset of two, and that padding bits are ignored, because those depend on what was written. The same applies to deferral across a mid-period write and to last-write-wins ordering. A reduced-width instance is swept over every code, and a full-width instance covers the extreme divisors.

// File: rtl/pclk_div_pkg.sv
package pclk_div_pkg;

    // Stored code is the divisor minus this amount
    localparam int unsigned CODE_OFFSET = 2;

    // Width needed to hold the largest divisor for a given code width
    function automatic int unsigned div_width(input int unsigned code_w);
        return code_w + 1;
    endfunction

endpackage

// File: rtl/pclk_cfg_stage.sv
module pclk_cfg_stage
    import pclk_div_pkg::*;
#(
    parameter int unsigned REG_W  = 16,
    parameter int unsigned LO_W   = 5,
    parameter int unsigned HI_W   = 5,
    parameter int unsigned HI_POS = 11,
    localparam int unsigned CODE_W = LO_W + HI_W,
    localparam int unsigned DIV_W  = div_width(CODE_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [REG_W-1:0] cfg_wdata,
    input  logic             tc,
    output logic             bypass_o,
    output logic [DIV_W-1:0] divisor_o
);

    localparam int unsigned BYP_POS = LO_W;

    typedef struct packed {
        logic              bypass;
        logic [CODE_W-1:0] code;
    } setting_t;

    typedef struct packed {
        setting_t pend;
        setting_t act;
    } state_t;

    state_t state_d, state_q;
    setting_t wr_setting;
    logic [CODE_W-1:0] wr_code;
    logic unused_bits;

    // Field extraction; the high part supplies the upper code bits
    generate
        if (HI_W > 0) begin : g_split
            assign wr_code = {cfg_wdata[HI_POS+HI_W-1:HI_POS], cfg_wdata[LO_W-1:0]};
        end else begin : g_low_only
            assign wr_code = cfg_wdata[LO_W-1:0];
        end
    endgenerate

    assign unused_bits = ^cfg_wdata;

    always_comb begin
        wr_setting.bypass = cfg_wdata[BYP_POS];
        wr_setting.code   = wr_code;

        state_d = state_q;
        if (cfg_we) begin
            state_d.pend = wr_setting;
        end
        if (tc) begin
            state_d.act = state_q.pend;
        end

        bypass_o = state_q.act.bypass;
        if (state_q.act.bypass) begin
            divisor_o = DIV_W'(1);
        end else begin
            divisor_o = DIV_W'(state_q.act.code) + DIV_W'(CODE_OFFSET);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/pclk_period_counter.sv
module pclk_period_counter #(
    parameter int unsigned DIV_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bypass,
    input  logic [DIV_W-1:0] divisor,
    output logic             tc,
    output logic             pix_en
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             en;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        tc   = bypass || (st_q.cnt == divisor - DIV_W'(1));
        if (tc) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + DIV_W'(1);
        end
        st_d.en = tc;
        pix_en  = st_q.en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/pclk_divider.sv
module pclk_divider #(
    parameter int unsigned REG_W  = 16,
    parameter int unsigned LO_W   = 5,
    parameter int unsigned HI_W   = 5,
    parameter int unsigned HI_POS = 11
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_we,
    input  logic [REG_W-1:0]       cfg_wdata,
    output logic                   pix_en,
    output logic [LO_W+HI_W:0]     div_eff
);

    localparam int unsigned DIV_W = pclk_div_pkg::div_width(LO_W + HI_W);

    logic             tc;
    logic             act_bypass;
    logic [DIV_W-1:0] act_div;

    pclk_cfg_stage #(
        .REG_W  (REG_W),
        .LO_W   (LO_W),
        .HI_W   (HI_W),
        .HI_POS (HI_POS)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .tc        (tc),
        .bypass_o  (act_bypass),
        .divisor_o (act_div)
    );

    pclk_period_counter #(
        .DIV_W (DIV_W)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .bypass  (act_bypass),
        .divisor (act_div),
        .tc      (tc),
        .pix_en  (pix_en)
    );

    assign div_eff = act_div;

endmodule

// File: rtl/pclk_divider_chk.sv
module pclk_divider_chk #(
    parameter int unsigned LO_W = 5,
    parameter int unsigned HI_W = 5,
    localparam int unsigned DIV_W   = LO_W + HI_W + 1,
    localparam int unsigned MAX_DIV = (2 ** (LO_W + HI_W)) + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pix_en,
    input logic [DIV_W-1:0] div_eff
);

    logic [DIV_W-1:0] gap_q;
    logic             seen_q;
    logic [DIV_W:0]   gap_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (pix_en) begin
            gap_q  <= '0;
            seen_q <= 1'b1;
        end else begin
            gap_q  <= gap_q + DIV_W'(1);
        end
    end

    assign gap_len = {1'b0, gap_q} + (DIV_W+1)'(1);

    // R4: a pulse is a single cycle unless bypass is in force
    assert_pulse_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_en && div_eff != DIV_W'(1)) |=> !pix_en);

    // R4, R6: each completed period matches the divisor in force during it
    assert_period_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_en && seen_q) |-> (gap_len == {1'b0, $past(div_eff)}));

    // R3: bypass keeps the enable high
    assert_bypass_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (div_eff == DIV_W'(1)) |=> pix_en);

    // R5: reported divisor stays within the legal range
    assert_div_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (div_eff >= DIV_W'(1)) && (div_eff <= DIV_W'(MAX_DIV)));

    // R6: the divisor changes only together with a pulse
    assert_load_on_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (div_eff != $past(div_eff)) |-> pix_en);

endmodule

bind pclk_divider pclk_divider_chk #(
    .LO_W (LO_W),
    .HI_W (HI_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .pix_en  (pix_en),
    .div_eff (div_eff)
);

// File: tb/pclk_divider_tb.sv
module pclk_divider_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    // Small instance: lo [1:0], bypass [2], pad [5:3], hi [7:6]
    logic       s_we = 1'b0;
    logic [7:0] s_wdata = '0;
    logic       s_pix;
    logic [4:0] s_div;

    // Full instance: lo [4:0], bypass [5], pad [10:6], hi [15:11]
    logic        b_we = 1'b0;
    logic [15:0] b_wdata = '0;
    logic        b_pix;
    logic [10:0] b_div;

    pclk_divider #(.REG_W(8), .LO_W(2), .HI_W(2), .HI_POS(6)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(s_we), .cfg_wdata(s_wdata),
        .pix_en(s_pix), .div_eff(s_div)
    );

    pclk_divider u_dut_full (
        .clk(clk), .rst_n(rst_n), .cfg_we(b_we), .cfg_wdata(b_wdata),
        .pix_en(b_pix), .div_eff(b_div)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int last_t[2] = '{0, 0};
    bit done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic pix_of(input int sel);
        return (sel == 0) ? s_pix : b_pix;
    endfunction

    task automatic write_cfg(input int sel, input int word);
        @(negedge clk);
        if (sel == 0) begin
            s_we = 1'b1; s_wdata = word[7:0];
        end else begin
            b_we = 1'b1; b_wdata = word[15:0];
        end
        @(negedge clk);
        s_we = 1'b0;
        b_we = 1'b0;
    endtask

    task automatic next_pulse(input int sel, output int per);
        int t0;
        t0 = last_t[sel];
        @(negedge clk);
        while (!pix_of(sel)) @(negedge clk);
        per = cyc - t0;
        last_t[sel] = cyc;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int per;
        repeat (3) @(negedge clk);
        chk("R1", "small pix_en in reset", s_pix, 0);
        chk("R1", "small div in reset", s_div, 2);
        chk("R1", "full pix_en in reset", b_pix, 0);
        chk("R1", "full div in reset", b_div, 2);
        rst_n = 1'b1;

        // R2, R4: sweep every code of the small instance, padding varied
        for (int code = 0; code < 16; code++) begin
            int word;
            word = ((code >> 2) << 6) | ((code & 7) << 3) | (code & 3);
            write_cfg(0, word);
            next_pulse(0, per);
            chk("R2", "divisor from split fields", s_div, code + 2);
            next_pulse(0, per);
            chk("R4", "period length", per, code + 2);
            @(negedge clk);
            chk("R4", "pulse one cycle wide", s_pix, 0);
        end

        // R3: bypass with all other bits set
        write_cfg(0, 8'hFF);
        next_pulse(0, per);
        chk("R3", "bypass divisor", s_div, 1);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R3", "bypass enable high", s_pix, 1);
        end

        // Leave bypass: hi=1 lo=1 -> code 5 -> divisor 7
        write_cfg(0, 8'h41);
        next_pulse(0, per);
        next_pulse(0, per);
        chk("R4", "period after leaving bypass", per, 7);

        // R6: mid-period write keeps the running period
        write_cfg(0, 8'hC3);
        next_pulse(0, per);
        next_pulse(0, per);
        chk("R6", "aligned period 17", per, 17);
        repeat (3) @(negedge clk);
        write_cfg(0, 8'h03);
        repeat (2) @(negedge clk);
        chk("R6", "divisor held mid-period", s_div, 17);
        next_pulse(0, per);
        chk("R6", "running period completes with old divisor", per, 17);
        chk("R6", "new divisor at terminal count", s_div, 5);
        next_pulse(0, per);
        chk("R6", "new period", per, 5);

        // R7: two writes in one period, last wins
        write_cfg(0, 8'hC3);
        next_pulse(0, per);
        next_pulse(0, per);
        write_cfg(0, 8'h82);
        write_cfg(0, 8'h01);
        next_pulse(0, per);
        chk("R7", "old period", per, 17);
        chk("R7", "last write wins", s_div, 3);
        next_pulse(0, per);
        chk("R7", "period of last write", per, 3);

        // R5: full instance extremes
        write_cfg(1, 16'hFFDF);
        next_pulse(1, per);
        chk("R5", "largest divisor", b_div, 1025);
        next_pulse(1, per);
        chk("R5", "largest period", per, 1025);
        write_cfg(1, 16'hF800);
        next_pulse(1, per);
        next_pulse(1, per);
        chk("R2", "high field only", per, 994);
        write_cfg(1, 16'h0020);
        next_pulse(1, per);
        chk("R3", "full bypass divisor", b_div, 1);
        @(negedge clk);
        chk("R3", "full bypass enable", b_pix, 1);
        write_cfg(1, 16'h07C0);
        next_pulse(1, per);
        chk("R2", "padding bits ignored", b_div, 2);
        next_pulse(1, per);
        chk("R5", "smallest period", per, 2);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule